// File: doc/BRIEF.md
# Timer compare interrupt unit

This unit watches a free-running system tick count supplied from outside and holds two compare words, one owned by the supervisor and one by the hypervisor. Each compare word is one bit wider than the counter. Its top bit is a disable flag, and only the lower bits are matched against the count. The counter itself is not part of the unit.

When the count moves onto the value held in an enabled compare word, the unit emits a single-cycle match pulse for that word. The supervisor pulse tells the soft interrupt register outside the unit to set its bit 16. The hypervisor pulse tells the hypervisor interrupt-pending flag to become 1. A hypervisor match is discarded while the thread is halted.

Software writes and reads both compare words through one simple port. A select bit picks the word, and reads return the whole word, disable flag included.

Top module: `tick_cmp_irq`

## Requirements
- R1: After reset both compare words read back as the disable flag set (bit CNT_W = 1) with all lower bits 0, and neither match output is asserted.
- R2: A write with `cmp_wr_en`=1 stores the full `cmp_wr_data` into the supervisor word when `cmp_wr_sel`=0 and into the hypervisor word when `cmp_wr_sel`=1. From the following cycle, `cmp_rd_data` returns the full word chosen by `cmp_rd_sel`, using the same 0/1 encoding.
- R3: When `tick_cnt` differs from its value in the previous cycle, equals bits CNT_W-1:0 of the supervisor word, and that word's bit CNT_W is 0, `sup_match` is 1 for exactly one cycle, starting one clock later. This pulse is the request to set soft interrupt bit 16.
- R4: A compare word whose bit CNT_W is 1 never produces a match pulse, whatever the count does.
- R5: A write to a compare word in the same cycle the count arrives at its value cancels that pending pulse. This includes a write with bit CNT_W set.
- R6: The hypervisor word follows the same match rule as R3 and drives `hyp_match`, which is the request to set the hypervisor interrupt-pending flag to 1.
- R7: A hypervisor arrival in a cycle with `thread_halted`=1 produces no `hyp_match`. `thread_halted` has no effect on `sup_match`.
- R8: A compare value written equal to or behind the current count does not fire while the count stays put. It fires only when the count next changes onto it, including after the count wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_wr_en | input | 1 | Compare word write strobe |
| cmp_wr_sel | input | 1 | Write target: 0 supervisor, 1 hypervisor |
| cmp_wr_data | input | CNT_W+1 | Write data; top bit is the disable flag |
| cmp_rd_sel | input | 1 | Read source: 0 supervisor, 1 hypervisor |
| cmp_rd_data | output | CNT_W+1 | Selected compare word |
| tick_cnt | input | CNT_W | External system tick count |
| thread_halted | input | 1 | Thread is halted; blocks hypervisor matches |
| sup_match | output | 1 | One-cycle supervisor match (set soft interrupt bit 16) |
| hyp_match | output | 1 | One-cycle hypervisor match (set pending flag) |

## Verification
The case that is hardest to reach is a compare write that lands in the very cycle the count arrives at the old compare value. The bench creates it by choosing the write cycle and the counter value together, so that a pending arrival and a disabling write coincide. A second hard case is a count that sits on, or jumps past, a freshly written value. The bench holds the count still after such writes, then moves it away and back, and also lets it wrap through zero. Everything else is covered by sweeping small compare values against a running count, with the halted input toggled in a pattern.

// File: rtl/tick_cmp_irq.sv
module tick_cmp_irq #(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr_en,
  input  logic             cmp_wr_sel,
  input  logic [CNT_W:0]   cmp_wr_data,
  input  logic             cmp_rd_sel,
  output logic [CNT_W:0]   cmp_rd_data,
  input  logic [CNT_W-1:0] tick_cnt,
  input  logic             thread_halted,
  output logic             sup_match,
  output logic             hyp_match
);
  localparam int CMP_W = CNT_W + 1;
  localparam logic [CMP_W-1:0] CMP_RST = {1'b1, {CNT_W{1'b0}}};

  logic [CMP_W-1:0] sup_cmp, hyp_cmp;
  logic [CNT_W-1:0] tick_prev;

  wire cnt_moved  = tick_cnt != tick_prev;
  wire sup_wr     = cmp_wr_en && !cmp_wr_sel;
  wire hyp_wr     = cmp_wr_en &&  cmp_wr_sel;

  wire sup_arrive = cnt_moved && !sup_cmp[CNT_W] && (tick_cnt == sup_cmp[CNT_W-1:0]);
  wire hyp_arrive = cnt_moved && !hyp_cmp[CNT_W] && (tick_cnt == hyp_cmp[CNT_W-1:0]);

  assign cmp_rd_data = cmp_rd_sel ? hyp_cmp : sup_cmp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sup_cmp   <= CMP_RST;
      hyp_cmp   <= CMP_RST;
      tick_prev <= '0;
      sup_match <= 1'b0;
      hyp_match <= 1'b0;
    end else begin
      tick_prev <= tick_cnt;
      if (sup_wr) sup_cmp <= cmp_wr_data;
      if (hyp_wr) hyp_cmp <= cmp_wr_data;
      sup_match <= sup_arrive && !sup_wr;
      hyp_match <= hyp_arrive && !hyp_wr && !thread_halted;
    end
  end

  // R4
  sup_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_match |-> !$past(sup_cmp[CNT_W]));

  // R4
  hyp_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_match |-> !$past(hyp_cmp[CNT_W]));

  // R5
  sup_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_en && !cmp_wr_sel) |=> !sup_match);

  // R5
  hyp_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_en && cmp_wr_sel) |=> !hyp_match);

  // R7
  hyp_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_match |-> !$past(thread_halted));

  // R8
  sup_moved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_match |-> (tick_prev != $past(tick_prev)));

  // R3
  sup_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_match |-> (tick_prev == $past(sup_cmp[CNT_W-1:0])));
endmodule

// File: tb/tick_cmp_irq_test.sv
module tick_cmp_irq_test;
  localparam int W = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic cmp_wr_en = 0, cmp_wr_sel = 0, cmp_rd_sel = 0, thread_halted = 0;
  logic [W:0] cmp_wr_data = '0;
  logic [W:0] cmp_rd_data;
  logic [W-1:0] tick_cnt = '0;
  logic sup_match, hyp_match;

  int total = 0, bad = 0;
  bit done = 0;

  logic [W:0] m_sup, m_hyp;
  logic [W-1:0] m_prev;

  always #5 clk = ~clk;

  tick_cmp_irq #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_wr_en(cmp_wr_en), .cmp_wr_sel(cmp_wr_sel),
    .cmp_wr_data(cmp_wr_data), .cmp_rd_sel(cmp_rd_sel), .cmp_rd_data(cmp_rd_data),
    .tick_cnt(tick_cnt), .thread_halted(thread_halted),
    .sup_match(sup_match), .hyp_match(hyp_match));

  task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive inputs, model the edge, check after it
  task automatic cyc(input string tag, input logic [W-1:0] cnt, input logic halt,
                     input logic we, input logic sel, input logic [W:0] wd, input logic rsel);
    logic es, eh, moved;
    tick_cnt = cnt; thread_halted = halt; cmp_wr_en = we; cmp_wr_sel = sel;
    cmp_wr_data = wd; cmp_rd_sel = rsel;
    @(posedge clk);
    moved = cnt != m_prev;
    es = moved && !m_sup[W] && cnt == m_sup[W-1:0] && !(we && !sel);
    eh = moved && !m_hyp[W] && cnt == m_hyp[W-1:0] && !(we && sel) && !halt;
    if (we && !sel) m_sup = wd;
    if (we && sel) m_hyp = wd;
    m_prev = cnt;
    @(negedge clk);
    cmp_wr_en = 0;
    chk({tag, " sup_match"}, {{W{1'b0}}, sup_match}, {{W{1'b0}}, es});
    chk({tag, " hyp_match"}, {{W{1'b0}}, hyp_match}, {{W{1'b0}}, eh});
    chk({tag, " R2 readback"}, cmp_rd_data, rsel ? m_hyp : m_sup);
  endtask

  initial begin
    m_sup = {1'b1, {W{1'b0}}}; m_hyp = {1'b1, {W{1'b0}}}; m_prev = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sup word", cmp_rd_data, {1'b1, {W{1'b0}}});
    chk("R1 sup_match", {{W{1'b0}}, sup_match}, '0);
    chk("R1 hyp_match", {{W{1'b0}}, hyp_match}, '0);
    cmp_rd_sel = 1; #1;
    chk("R1 hyp word", cmp_rd_data, {1'b1, {W{1'b0}}});
    rst_n = 1;
    // R4: reset values are disabled; count through 0..12 gives no pulse
    for (int c = 0; c < 13; c++) cyc("R4 reset-disabled", W'(c), 0, 0, 0, '0, c[0]);

    // R3 R6 R7 sweep: many compare values, halted pattern
    for (int v = 1; v < 24; v++) begin
      cyc("R2 wr sup", '0, 0, 1, 0, {1'b0, W'(v)}, 0);
      cyc("R2 wr hyp", '0, 0, 1, 1, {1'b0, W'((v * 3) % 29)}, 1);
      for (int c = 1; c < 30; c++)
        cyc("R3 R6 R7 sweep", W'(c), (c % 4) == (v % 4), 0, 0, '0, c[0]);
    end

    // R4: disable flag set with matching low bits
    cyc("R4 wr sup", 8'd40, 0, 1, 0, {1'b1, 8'd45}, 0);
    cyc("R4 wr hyp", 8'd41, 0, 1, 1, {1'b1, 8'd47}, 1);
    for (int c = 42; c < 52; c++) cyc("R4 disabled", W'(c), 0, 0, 0, '0, c[0]);

    // R5: write with disable flag in the arrival cycle
    cyc("R5 setup sup", 8'd60, 0, 1, 0, {1'b0, 8'd62}, 0);
    cyc("R5 setup hyp", 8'd61, 0, 1, 1, {1'b0, 8'd63}, 1);
    cyc("R5 cancel sup", 8'd62, 0, 1, 0, {1'b1, 8'd62}, 0);
    cyc("R5 cancel hyp", 8'd63, 0, 1, 1, {1'b1, 8'd63}, 1);
    cyc("R5 after", 8'd64, 0, 0, 0, '0, 0);

    // R8: value equal to / behind count does not fire while count holds
    cyc("R8 wr sup eq", 8'd90, 0, 1, 0, {1'b0, 8'd90}, 0);
    cyc("R8 wr hyp behind", 8'd90, 0, 1, 1, {1'b0, 8'd80}, 1);
    for (int i = 0; i < 5; i++) cyc("R8 hold", 8'd90, 0, 0, 0, '0, i[0]);
    cyc("R8 away", 8'd89, 0, 0, 0, '0, 0);
    cyc("R8 back sup", 8'd90, 0, 0, 0, '0, 0);
    for (int c = 250; c < 256; c++) cyc("R8 approach wrap", W'(c), 0, 0, 0, '0, 1);
    for (int c = 0; c < 82; c++) cyc("R8 wrap to hyp", W'(c), 0, 0, 0, '0, 1);

    // R7: sup unaffected by halt; hyp blocked then fires next arrival
    cyc("R7 wr sup", 8'd100, 0, 1, 0, {1'b0, 8'd102}, 0);
    cyc("R7 wr hyp", 8'd101, 1, 1, 1, {1'b0, 8'd102}, 1);
    cyc("R7 arrive halted", 8'd102, 1, 0, 0, '0, 0);
    cyc("R7 away", 8'd103, 0, 0, 0, '0, 0);
    cyc("R7 arrive running", 8'd102, 0, 0, 0, '0, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule